// File: doc/BRIEF.md
# Coin Credit Vend Controller

This block keeps a running money total for one drink and decides when the drink is paid for. Each coin arrives as a one-cycle valid pulse with a 2-bit denomination code. The total is kept as an explicit finite state counted in 5-cent units. The price is 90 cents. While the total stays below the price, the coin's value is added to the credit. When a coin brings the total to the price or beyond, the block raises a dispense pulse and reports the surplus as change. In the same clock it returns to zero credit.

The outputs are registered. The results of a coin sampled on one rising edge can be read from the ports right after that edge. The credit seen outside is always a multiple of five cents in the range 0 to 85.

Top module: `vend_credit_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is zero credit, with `dispense` low, `change_valid` low and `change_cents` zero.
- R2: When `coin_valid` is high, the coin code is worth 5 cents (00), 10 cents (01), 25 cents (10) or 100 cents (11).
- R3: A sampled coin whose value plus the credit stays below 90 raises `credit_cents` by the coin value after the edge. `dispense` and `change_valid` stay low.
- R4: A sampled coin that brings the total to 90 or more does three things after the edge. It raises `dispense` and `change_valid`, sets `change_cents` to the total minus 90, and sets `credit_cents` to 0.
- R5: A total of exactly 90 vends with `change_valid` high and `change_cents` equal to 0.
- R6: With `coin_valid` low, `coin_code` has no effect. The credit holds, and no dispense or change follows.
- R7: `dispense` and `change_valid` are single-cycle pulses. They are low after any edge at which no coin was sampled.
- R8: `credit_cents` is always a multiple of 5 and below 90.
- R9: `change_valid` always equals `dispense`, and `change_cents` is 0 whenever `change_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coin_valid | input | 1 | One-cycle strobe: a coin is present |
| coin_code | input | 2 | Coin denomination code (see R2) |
| dispense | output | 1 | One-cycle vend pulse |
| change_valid | output | 1 | One-cycle pulse, change amount valid |
| change_cents | output | 7 | Change to return, in cents |
| credit_cents | output | 7 | Credit currently held, in cents |

## Verification
Some properties are checked on every cycle by assertions:
- the credit stays below the price;
- the dispense and change-valid pulses agree;
- change is zero when not valid;
- an idle cycle leaves the credit unchanged and produces no vend;
- a dollar coin always vends;
- a nickel on a low credit adds exactly five cents.

Other behaviour only the bench's scenarios can show against its reference model:
- the exact change for each total;
- the exact-price case with zero change;
- the value of every coin code from zero credit;
- long mixed coin streams and reset in the middle of an accumulation.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int UNIT_CENTS = 5;
    localparam int UNITS_W    = 6;
    localparam int CENTS_W    = 7;
    localparam int WIDE_W     = UNITS_W + 3;

    typedef enum logic [1:0] {
        COIN_NICKEL  = 2'b00,
        COIN_DIME    = 2'b01,
        COIN_QUARTER = 2'b10,
        COIN_DOLLAR  = 2'b11
    } coin_e;

    typedef logic [UNITS_W-1:0] units_t;
    typedef logic [CENTS_W-1:0] cents_t;

    typedef struct packed {
        logic   vend;
        units_t next_credit;
        units_t excess;
    } decision_t;

    function automatic units_t coin_units(coin_e c);
        units_t u;
        case (c)
            COIN_NICKEL:  u = units_t'(1);
            COIN_DIME:    u = units_t'(2);
            COIN_QUARTER: u = units_t'(5);
            default:      u = units_t'(20);
        endcase
        return u;
    endfunction

    function automatic cents_t units_to_cents(units_t u);
        logic [WIDE_W-1:0] w;
        w = {3'b000, u} * WIDE_W'(UNIT_CENTS);
        return w[CENTS_W-1:0];
    endfunction

endpackage

// File: rtl/vend_coin_value.sv
module vend_coin_value
    import vend_pkg::*;
(
    input  logic [1:0] code,
    output units_t     value
);
    always_comb value = coin_units(coin_e'(code));
endmodule

// File: rtl/vend_decide.sv
module vend_decide
    import vend_pkg::*;
#(
    parameter int PRICE_UNITS = 18
) (
    input  logic      coin_ok,
    input  units_t    credit_q,
    input  units_t    coin_val,
    output decision_t dec
);
    localparam units_t PRICE_U = units_t'(PRICE_UNITS);

    units_t total;

    always_comb begin
        total           = credit_q + coin_val;
        dec.vend        = 1'b0;
        dec.next_credit = credit_q;
        dec.excess      = '0;
        if (coin_ok) begin
            if (total >= PRICE_U) begin
                dec.vend        = 1'b1;
                dec.next_credit = '0;
                dec.excess      = total - PRICE_U;
            end else begin
                dec.next_credit = total;
            end
        end
    end
endmodule

// File: rtl/vend_state_regs.sv
module vend_state_regs
    import vend_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  decision_t dec,
    output units_t    credit_q,
    output logic      vend_q,
    output cents_t    change_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            credit_q <= '0;
            vend_q   <= 1'b0;
            change_q <= '0;
        end else begin
            credit_q <= dec.next_credit;
            vend_q   <= dec.vend;
            change_q <= dec.vend ? units_to_cents(dec.excess) : '0;
        end
    end
endmodule

// File: rtl/vend_credit_ctrl.sv
module vend_credit_ctrl
    import vend_pkg::*;
#(
    parameter int PRICE_CENTS = 90
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       coin_valid,
    input  logic [1:0] coin_code,
    output logic       dispense,
    output logic       change_valid,
    output logic [6:0] change_cents,
    output logic [6:0] credit_cents
);
    localparam int PRICE_UNITS = PRICE_CENTS / UNIT_CENTS;

    units_t    coin_val;
    units_t    credit_q;
    decision_t dec;
    logic      vend_q;
    cents_t    change_q;

    vend_coin_value u_value (
        .code  (coin_code),
        .value (coin_val)
    );

    vend_decide #(.PRICE_UNITS(PRICE_UNITS)) u_decide (
        .coin_ok  (coin_valid),
        .credit_q (credit_q),
        .coin_val (coin_val),
        .dec      (dec)
    );

    vend_state_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .dec      (dec),
        .credit_q (credit_q),
        .vend_q   (vend_q),
        .change_q (change_q)
    );

    assign dispense     = vend_q;
    assign change_valid = vend_q;
    assign change_cents = change_q;
    assign credit_cents = units_to_cents(credit_q);

    assert_credit_below_price_R8: assert property (@(posedge clk) disable iff (rst)
        credit_cents < 7'(PRICE_CENTS));

    assert_change_zero_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !change_valid |-> change_cents == 7'd0);

    assert_pulse_pair_R9: assert property (@(posedge clk) disable iff (rst)
        dispense == change_valid);

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !coin_valid |=> ($stable(credit_cents) && !dispense));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (dispense && !coin_valid) |=> !dispense);

    assert_dollar_vends_R2: assert property (@(posedge clk) disable iff (rst)
        (coin_valid && coin_code == 2'b11) |=> (dispense && credit_cents == 7'd0));

    assert_nickel_adds_R3: assert property (@(posedge clk) disable iff (rst)
        (coin_valid && coin_code == 2'b00 && credit_cents < 7'd85)
        |=> (!dispense && credit_cents == $past(credit_cents) + 7'd5));
endmodule

// File: tb/sim_vend_credit_ctrl.sv
`timescale 1ns/1ps
module sim_vend_credit_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       coin_valid = 1'b0;
    logic [1:0] coin_code = 2'b00;
    logic       dispense, change_valid;
    logic [6:0] change_cents, credit_cents;

    always #2.5 clk = ~clk;

    vend_credit_ctrl u0 (
        .clk(clk), .rst(rst), .coin_valid(coin_valid), .coin_code(coin_code),
        .dispense(dispense), .change_valid(change_valid),
        .change_cents(change_cents), .credit_cents(credit_cents)
    );

    integer tests = 0, fails = 0, cycles = 0;
    integer m_credit = 0, m_change = 0;
    bit     m_disp = 1'b0, m_prev_disp = 1'b0, m_started = 1'b0, done = 1'b0;
    string  m_tag = "R1";

    function automatic integer value_of(logic [1:0] c);
        case (c)
            2'b00: return 5;
            2'b01: return 10;
            2'b10: return 25;
            default: return 100;
        endcase
    endfunction

    always @(posedge clk) begin
        integer tot;
        cycles = cycles + 1;
        m_started = 1'b1;
        m_prev_disp = m_disp;
        if (rst) begin
            m_credit = 0; m_disp = 0; m_change = 0; m_tag = "R1";
        end else if (coin_valid) begin
            tot = m_credit + value_of(coin_code);
            if (tot >= 90) begin
                m_disp = 1; m_change = tot - 90; m_credit = 0;
                m_tag = (tot == 90) ? "R5" : "R4";
            end else begin
                m_disp = 0; m_change = 0; m_credit = tot; m_tag = "R3";
            end
        end else begin
            m_disp = 0; m_change = 0;
            m_tag = m_prev_disp ? "R7" : "R6";
        end
    end

    task automatic check(string tag, string what, integer act, integer exp);
        tests = tests + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (m_started && !done) begin
            check(m_tag, "credit_cents", credit_cents, m_credit);
            check(m_tag, "dispense", dispense, m_disp);
            check(m_tag, "change_cents", change_cents, m_change);
            check("R9", "change_valid vs dispense", change_valid, dispense);
            check("R8", "credit below price, step 5",
                  (credit_cents < 90 && credit_cents % 5 == 0) ? 1 : 0, 1);
        end
    end

    task automatic insert(logic [1:0] c);
        @(negedge clk);
        coin_valid = 1'b1; coin_code = c;
        @(negedge clk);
        coin_valid = 1'b0; coin_code = ~c;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            coin_valid = 1'b0; coin_code = 2'(i);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cycles > 100000 && !done) begin
            tests = tests + 1; fails = fails + 1;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
            summary();
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2: each code from zero credit
        for (int c = 0; c < 4; c++) begin
            insert(2'(c));
            check("R2", "credit or change after single coin",
                  (c == 3) ? change_cents : credit_cents, (c == 3) ? 10 : value_of(2'(c)));
            do_reset();
        end
        // R5: eighteen nickels reach exactly 90
        for (int i = 0; i < 18; i++) begin
            @(negedge clk); coin_valid = 1'b1; coin_code = 2'b00;
        end
        @(negedge clk); coin_valid = 1'b0;
        check("R5", "exact price dispense", dispense, 1);
        idle(2);
        // R4: four quarters gives 10 change
        repeat (4) insert(2'b10);
        idle(1);
        // R4: 85 credit then dollar gives 95 change
        repeat (3) insert(2'b10);
        insert(2'b01);
        check("R3", "credit at 85", credit_cents, 85);
        insert(2'b11);
        check("R4", "max change", change_cents, 95);
        // R6: idle with codes toggling
        insert(2'b01);
        idle(8);
        check("R6", "credit held while idle", credit_cents, 10);
        // R1: reset mid credit
        do_reset();
        check("R1", "credit after reset", credit_cents, 0);
        // random mixed stream, back to back allowed
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            coin_valid = lfsr[0] | lfsr[3];
            coin_code  = lfsr[5:4];
            if (lfsr[15:9] == 7'd0) rst = 1'b1; else rst = 1'b0;
        end
        @(negedge clk); coin_valid = 1'b0; rst = 1'b0;
        idle(3);
        summary();
    end
endmodule